// File: doc/BRIEF.md
# Bus Address Range Trigger Comparator

This block watches a processor bus and, on every valid access, compares the access address against two programmable comparator values, called A and B. A mode field chooses how the two comparisons are combined. The choices are: single equality matches, an A-then-B sequence, event-style repeating triggers, full-mode matches where B qualifies only the access direction, and inside-window or outside-window range checks. Each qualifying access sets sticky per-comparator flags and produces a one-cycle trigger pulse. A second output marks whether that trigger is an end-type or a begin-type trigger.

Software programs three registers through a small write port: a control word, comparator A and comparator B. A word-select control bit changes how exact the comparisons are. When it is set, the lowest address bit is dropped and any direction qualification is ignored. A detail-capture bit turns the event-style modes into their plain counterparts. A sequencer with named states (IDLE, ARMED, DONE) tracks the A-then-B modes. A flag-clear strobe or any register write returns the sequencer to IDLE.

Top module: `bus_range_trigger`

## Requirements
- R1: After reset, flag_a, flag_b, trig and trig_is_end are 0. The control word, A and B are all zero, and mode code 0 means the comparator is off.
- R2: For a valid bus access that qualifies, flags are set at the next clock edge and trig is high for exactly that one following cycle. Flags stay set until they are cleared.
- R3: A cycle with flag_clr or cfg_we high clears both flags, sends the sequencer to IDLE and ignores any bus access in that same cycle. cfg_addr 0 writes the control word, 1 writes A, 2 writes B and 3 writes nothing. The control word fields are: bits [3:0] mode, bit 4 word select, bit 5 detail, bit 6 end type, bit 7 A direction enable, bit 8 A direction value (1 = read), bit 9 B direction enable, bit 10 B direction value.
- R4: In mode 1 (A only), an access equal to A sets flag_a and triggers. In mode 2 (A or B), an equal-to-A access sets flag_a, an equal-to-B access sets flag_b, and either one triggers.
- R5: In mode 3 (A then B), the sequencer goes from IDLE to ARMED on an A match and sets flag_a. In ARMED, a B match sets flag_b, triggers and moves to DONE. A B match in IDLE and any match in DONE have no effect.
- R6: With detail clear, mode 4 (event-only B) triggers on every B match. Mode 5 (A then event-only B) stays ARMED and triggers on every B match after the A match. Triggers from these modes are begin-type: trig_is_end stays 0. For all other triggers, trig_is_end equals the end-type bit.
- R7: With detail set, mode 4 behaves as B only and mode 5 behaves as mode 3. In both cases trig_is_end follows the end-type bit.
- R8: In mode 6 (A and B), a match on A together with B's direction condition sets both flags and triggers. In mode 7 (A and not B), a match on A with B's direction condition enabled and failed sets flag_a and triggers. When word select is set, both modes reduce to A only.
- R9: In mode 8 (inside), a trigger fires and both flags are set only when A ≤ address ≤ B holds in full. If only one bound holds, no flag is set.
- R10: In mode 9 (outside), address < A sets flag_a, address > B sets flag_b, and either one triggers.
- R11: With word select set, address bit 0 of the access, A and B is ignored in every comparison, and the direction enables are ignored.
- R12: With word select clear, an access is judged by its own (aligned) address alone. A word at an even address that straddles a window bound triggers only if that address is on the qualifying side.
- R13: With word select clear and a comparator's direction enable set, that comparator's condition holds only when bus_rd equals its direction value.
- R14: Mode codes 0 and 10 to 15 never set a flag or trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | A bus access is present this cycle |
| bus_addr | input | AW | Access address |
| bus_rd | input | 1 | 1 = read access, 0 = write access |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 control, 1 A, 2 B |
| cfg_wdata | input | AW | Register write data |
| flag_clr | input | 1 | Clears both flags and the sequencer |
| flag_a | output | 1 | Sticky comparator A flag |
| flag_b | output | 1 | Sticky comparator B flag |
| trig | output | 1 | One-cycle trigger pulse |
| trig_is_end | output | 1 | Trigger is end-type (valid with trig) |

## Verification
Every result comes from one register stage. The bus access, clear or write presented before a rising edge shows up in the flags, trig and trig_is_end right after that edge. A register write takes effect for the access in the following cycle. The bench drives each cycle's inputs just after a falling edge and advances its own expected state for that cycle. At the next falling edge it compares all four outputs, so every comparison sits half a period away from the edge that produced it.

// File: rtl/brt_pkg.sv
package brt_pkg;

    localparam int CTRL_W = 11;

    typedef enum logic [3:0] {
        M_OFF         = 4'd0,
        M_A_ONLY      = 4'd1,
        M_A_OR_B      = 4'd2,
        M_A_THEN_B    = 4'd3,
        M_EV_B        = 4'd4,
        M_A_THEN_EVB  = 4'd5,
        M_A_AND_B     = 4'd6,
        M_A_AND_NOT_B = 4'd7,
        M_INSIDE      = 4'd8,
        M_OUTSIDE     = 4'd9,
        M_B_ONLY      = 4'd10
    } mode_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ARMED = 2'd1,
        S_DONE  = 2'd2
    } seq_e;

    typedef struct packed {
        logic       rwb_rd;
        logic       rwb_en;
        logic       rwa_rd;
        logic       rwa_en;
        logic       end_type;
        logic       detail;
        logic       wsel;
        logic [3:0] mode;
    } ctrl_t;

endpackage

// File: rtl/brt_addr_cmp.sv
module brt_addr_cmp #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] cmp_a,
    input  logic [AW-1:0] cmp_b,
    input  logic          wsel,
    output logic          eq_a,
    output logic          eq_b,
    output logic          ge_a,
    output logic          le_b
);
    localparam logic [AW-1:0] WORD_MASK = {{(AW-1){1'b1}}, 1'b0};
    localparam logic [AW-1:0] BYTE_MASK = {AW{1'b1}};

    logic [AW-1:0] mask;
    logic [AW-1:0] a_eff;
    logic [AW-1:0] ca_eff;
    logic [AW-1:0] cb_eff;

    always_comb begin
        mask   = wsel ? WORD_MASK : BYTE_MASK;
        a_eff  = addr  & mask;
        ca_eff = cmp_a & mask;
        cb_eff = cmp_b & mask;
        eq_a   = (a_eff == ca_eff);
        eq_b   = (a_eff == cb_eff);
        ge_a   = (a_eff >= ca_eff);
        le_b   = (a_eff <= cb_eff);
    end
endmodule

// File: rtl/brt_mode_res.sv
module brt_mode_res
    import brt_pkg::*;
(
    input  ctrl_t ctrl,
    input  logic  bus_rd,
    output mode_e eff_mode,
    output logic  evonly,
    output logic  is_end,
    output logic  qa,
    output logic  qb,
    output logic  b_full,
    output logic  b_not
);
    always_comb begin
        unique case (ctrl.mode)
            4'd1:    eff_mode = M_A_ONLY;
            4'd2:    eff_mode = M_A_OR_B;
            4'd3:    eff_mode = M_A_THEN_B;
            4'd4:    eff_mode = ctrl.detail ? M_B_ONLY : M_EV_B;
            4'd5:    eff_mode = ctrl.detail ? M_A_THEN_B : M_A_THEN_EVB;
            4'd6:    eff_mode = M_A_AND_B;
            4'd7:    eff_mode = M_A_AND_NOT_B;
            4'd8:    eff_mode = M_INSIDE;
            4'd9:    eff_mode = M_OUTSIDE;
            default: eff_mode = M_OFF;
        endcase
        evonly = (eff_mode == M_EV_B) || (eff_mode == M_A_THEN_EVB);
        is_end = ctrl.end_type && !evonly;
        // word select overrides any direction qualification
        qa     = ctrl.wsel || !ctrl.rwa_en || (bus_rd == ctrl.rwa_rd);
        qb     = ctrl.wsel || !ctrl.rwb_en || (bus_rd == ctrl.rwb_rd);
        b_full = ctrl.wsel || !ctrl.rwb_en || (bus_rd == ctrl.rwb_rd);
        b_not  = ctrl.wsel || (ctrl.rwb_en && (bus_rd != ctrl.rwb_rd));
    end
endmodule

// File: rtl/brt_seq.sv
module brt_seq
    import brt_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr,
    input  logic  valid,
    input  mode_e eff_mode,
    input  logic  evonly,
    input  logic  is_end,
    input  logic  qa,
    input  logic  qb,
    input  logic  b_full,
    input  logic  b_not,
    input  logic  eq_a,
    input  logic  eq_b,
    input  logic  ge_a,
    input  logic  le_b,
    output logic  flag_a,
    output logic  flag_b,
    output logic  trig,
    output logic  trig_is_end
);
    seq_e state_q, state_d;
    logic set_a, set_b, fire;
    logic m_a, m_b, in_a, in_b, out_a, out_b;

    always_comb begin
        m_a   = eq_a && qa;
        m_b   = eq_b && qb;
        in_a  = ge_a && qa;
        in_b  = le_b && qb;
        out_a = !ge_a && qa;
        out_b = !le_b && qb;
    end

    always_comb begin
        state_d = state_q;
        set_a   = 1'b0;
        set_b   = 1'b0;
        fire    = 1'b0;
        if (clr) begin
            state_d = S_IDLE;
        end else if (valid) begin
            unique case (eff_mode)
                M_A_ONLY: begin
                    set_a = m_a;
                    fire  = m_a;
                end
                M_B_ONLY, M_EV_B: begin
                    set_b = m_b;
                    fire  = m_b;
                end
                M_A_OR_B: begin
                    set_a = m_a;
                    set_b = m_b;
                    fire  = m_a || m_b;
                end
                M_A_THEN_B, M_A_THEN_EVB: begin
                    unique case (state_q)
                        S_IDLE: begin
                            if (m_a) begin
                                set_a   = 1'b1;
                                state_d = S_ARMED;
                            end
                        end
                        S_ARMED: begin
                            if (m_b) begin
                                set_b   = 1'b1;
                                fire    = 1'b1;
                                state_d = evonly ? S_ARMED : S_DONE;
                            end
                        end
                        default: state_d = S_DONE;
                    endcase
                end
                M_A_AND_B: begin
                    set_a = m_a && b_full;
                    set_b = m_a && b_full;
                    fire  = m_a && b_full;
                end
                M_A_AND_NOT_B: begin
                    set_a = m_a && b_not;
                    fire  = m_a && b_not;
                end
                M_INSIDE: begin
                    set_a = in_a && in_b;
                    set_b = in_a && in_b;
                    fire  = in_a && in_b;
                end
                M_OUTSIDE: begin
                    set_a = out_a;
                    set_b = out_b;
                    fire  = out_a || out_b;
                end
                default: begin
                    fire = 1'b0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            flag_a      <= 1'b0;
            flag_b      <= 1'b0;
            trig        <= 1'b0;
            trig_is_end <= 1'b0;
        end else begin
            flag_a      <= flag_a | set_a;
            flag_b      <= flag_b | set_b;
            trig        <= fire;
            trig_is_end <= fire && is_end;
        end
    end
endmodule

// File: rtl/bus_range_trigger.sv
module bus_range_trigger
    import brt_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_valid,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_rd,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_addr,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          flag_clr,
    output logic          flag_a,
    output logic          flag_b,
    output logic          trig,
    output logic          trig_is_end
);
    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_A    = 2'd1;
    localparam logic [1:0] SEL_B    = 2'd2;

    ctrl_t         ctrl_q;
    logic [AW-1:0] cmp_a_q;
    logic [AW-1:0] cmp_b_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            cmp_a_q <= '0;
            cmp_b_q <= '0;
        end else if (cfg_we) begin
            if (cfg_addr == SEL_CTRL) ctrl_q  <= ctrl_t'(cfg_wdata[CTRL_W-1:0]);
            if (cfg_addr == SEL_A)    cmp_a_q <= cfg_wdata;
            if (cfg_addr == SEL_B)    cmp_b_q <= cfg_wdata;
        end
    end

    logic  eq_a, eq_b, ge_a, le_b;
    mode_e eff_mode;
    logic  evonly, is_end, qa, qb, b_full, b_not;

    brt_addr_cmp #(.AW(AW)) u_cmp (
        .addr  (bus_addr),
        .cmp_a (cmp_a_q),
        .cmp_b (cmp_b_q),
        .wsel  (ctrl_q.wsel),
        .eq_a  (eq_a),
        .eq_b  (eq_b),
        .ge_a  (ge_a),
        .le_b  (le_b)
    );

    brt_mode_res u_res (
        .ctrl     (ctrl_q),
        .bus_rd   (bus_rd),
        .eff_mode (eff_mode),
        .evonly   (evonly),
        .is_end   (is_end),
        .qa       (qa),
        .qb       (qb),
        .b_full   (b_full),
        .b_not    (b_not)
    );

    brt_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (flag_clr || cfg_we),
        .valid       (bus_valid),
        .eff_mode    (eff_mode),
        .evonly      (evonly),
        .is_end      (is_end),
        .qa          (qa),
        .qb          (qb),
        .b_full      (b_full),
        .b_not       (b_not),
        .eq_a        (eq_a),
        .eq_b        (eq_b),
        .ge_a        (ge_a),
        .le_b        (le_b),
        .flag_a      (flag_a),
        .flag_b      (flag_b),
        .trig        (trig),
        .trig_is_end (trig_is_end)
    );
endmodule

// File: rtl/brt_chk.sv
module brt_chk
    import brt_pkg::*;
(
    input logic  clk,
    input logic  rst_n,
    input logic  bus_valid,
    input logic  cfg_we,
    input logic  flag_clr,
    input logic  flag_a,
    input logic  flag_b,
    input logic  trig,
    input logic  trig_is_end,
    input ctrl_t ctrl_q
);
    // R2
    trig_from_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> $past(bus_valid));

    // R2
    flag_a_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_a && !flag_clr && !cfg_we) |=> flag_a);

    // R2
    flag_b_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_b) |-> $past(bus_valid));

    // R3
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr || cfg_we) |=> (!flag_a && !flag_b && !trig));

    // R6
    end_needs_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_is_end |-> trig);

    // R9
    inside_both_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && ctrl_q.mode == 4'd8) |-> (flag_a && flag_b));

    // R14
    off_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.mode == 4'd0 && !cfg_we) |=> !trig);
endmodule

bind bus_range_trigger brt_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_valid   (bus_valid),
    .cfg_we      (cfg_we),
    .flag_clr    (flag_clr),
    .flag_a      (flag_a),
    .flag_b      (flag_b),
    .trig        (trig),
    .trig_is_end (trig_is_end),
    .ctrl_q      (ctrl_q)
);

// File: tb/bus_range_trigger_bench.sv
module bus_range_trigger_bench;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_valid = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_rd = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_addr = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          flag_clr = 1'b0;
    logic          flag_a, flag_b, trig, trig_is_end;

    bus_range_trigger #(.AW(AW)) u_bus_range_trigger (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .flag_clr(flag_clr), .flag_a(flag_a), .flag_b(flag_b), .trig(trig),
        .trig_is_end(trig_is_end)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int cyc_cnt = 0;

    // expected state
    logic [3:0]    m_mode = 0;
    logic          m_wsel = 0, m_det = 0, m_end = 0;
    logic          m_rwa_en = 0, m_rwa_rd = 0, m_rwb_en = 0, m_rwb_rd = 0;
    logic [AW-1:0] m_a = 0, m_b = 0;
    logic          e_fa = 0, e_fb = 0, e_trig = 0, e_end = 0;
    int            m_seq = 0; // 0 idle, 1 armed, 2 done

    task automatic check(input logic [3:0] act, input logic [3:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {fa,fb,trig,end} actual %b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [3:0] outs();
        return {flag_a, flag_b, trig, trig_is_end};
    endfunction

    task automatic model_step(input logic v, input logic [AW-1:0] addr, input logic rd,
                              input logic clr);
        logic [AW-1:0] msk, ea, ca, cb;
        logic qa, qb, ma, mb, fire, ev;
        e_trig = 0;
        e_end  = 0;
        if (clr) begin
            e_fa = 0; e_fb = 0; m_seq = 0;
            return;
        end
        if (!v) return;
        msk  = m_wsel ? {{(AW-1){1'b1}}, 1'b0} : {AW{1'b1}};
        ea   = addr & msk; ca = m_a & msk; cb = m_b & msk;
        qa   = m_wsel || !m_rwa_en || (rd == m_rwa_rd);
        qb   = m_wsel || !m_rwb_en || (rd == m_rwb_rd);
        ma   = (ea == ca) && qa;
        mb   = (ea == cb) && qb;
        ev   = !m_det && (m_mode == 4 || m_mode == 5);
        fire = 0;
        case (m_mode)
            1: if (ma) begin e_fa = 1; fire = 1; end
            2: begin
                if (ma) e_fa = 1;
                if (mb) e_fb = 1;
                fire = ma || mb;
            end
            3, 5: begin
                if (m_seq == 0 && ma) begin e_fa = 1; m_seq = 1; end
                else if (m_seq == 1 && mb) begin
                    e_fb = 1; fire = 1;
                    m_seq = (m_mode == 5 && !m_det) ? 1 : 2;
                end
            end
            4: if (mb) begin e_fb = 1; fire = 1; end
            6: if (ma && (m_wsel || !m_rwb_en || rd == m_rwb_rd)) begin
                e_fa = 1; e_fb = 1; fire = 1;
            end
            7: if (ma && (m_wsel || (m_rwb_en && rd != m_rwb_rd))) begin
                e_fa = 1; fire = 1;
            end
            8: if (ea >= ca && qa && ea <= cb && qb) begin
                e_fa = 1; e_fb = 1; fire = 1;
            end
            9: begin
                if (ea < ca && qa) begin e_fa = 1; fire = 1; end
                if (ea > cb && qb) begin e_fb = 1; fire = 1; end
            end
            default: fire = 0;
        endcase
        e_trig = fire;
        e_end  = fire && m_end && !ev;
    endtask

    // one bus cycle, checked half a period after the capturing edge
    task automatic cyc(input logic v, input logic [AW-1:0] addr, input logic rd,
                       input logic clr, input string req);
        bus_valid = v; bus_addr = addr; bus_rd = rd; flag_clr = clr; cfg_we = 0;
        model_step(v, addr, rd, clr);
        @(negedge clk);
        check(outs(), {e_fa, e_fb, e_trig, e_end}, req);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [AW-1:0] data, input string req);
        cfg_we = 1; cfg_addr = sel; cfg_wdata = data; bus_valid = 1; flag_clr = 0;
        bus_addr = m_a; // an access during a write must be ignored (R3)
        model_step(1'b0, '0, 1'b0, 1'b1);
        if (sel == 0) begin
            {m_rwb_rd, m_rwb_en, m_rwa_rd, m_rwa_en, m_end, m_det, m_wsel, m_mode} = data[10:0];
        end else if (sel == 1) m_a = data;
        else if (sel == 2) m_b = data;
        @(negedge clk);
        cfg_we = 0; bus_valid = 0;
        check(outs(), {e_fa, e_fb, e_trig, e_end}, req);
    endtask

    task automatic set_ctrl(input logic [3:0] mode, input logic wsel, input logic det,
                            input logic en, input logic [3:0] rw, input string req);
        logic [AW-1:0] d;
        d = '0;
        d[10:0] = {rw[3], rw[2], rw[1], rw[0], en, det, wsel, mode};
        wr(2'd0, d, req);
    endtask

    task automatic expect_trig(input logic exp, input string req);
        n_chk++;
        if (trig !== exp) begin
            n_bad++;
            $display("FAIL %s: trig actual %b expected %b", req, trig, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc_cnt++;
            if (cyc_cnt > 100000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual hung expected completion");
                finish_run();
            end
        end
    end

    initial begin
        void'($urandom(32'h5EED_2024));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state, mode off
        check(outs(), 4'b0000, "R1");
        cyc(1, 16'h0000, 1, 0, "R1 R14 off at address zero");

        // R4: A only, A or B
        wr(2'd1, 16'h0200, "R3");
        wr(2'd2, 16'h0204, "R3");
        set_ctrl(4'd1, 0, 0, 1, 4'b0000, "R3");
        cyc(1, 16'h0204, 0, 0, "R4 A only miss");
        cyc(1, 16'h0200, 0, 0, "R4 A only hit");
        cyc(0, 16'h0200, 0, 0, "R2 pulse ends flag holds");
        cyc(0, 16'h0000, 0, 1, "R3 clear");
        set_ctrl(4'd2, 0, 0, 0, 4'b0000, "R3");
        cyc(1, 16'h0204, 0, 0, "R4 A or B via B");
        cyc(1, 16'h0200, 0, 0, "R4 A or B via A");

        // R5: A then B
        set_ctrl(4'd3, 0, 0, 1, 4'b0000, "R3");
        cyc(1, 16'h0204, 0, 0, "R5 B in IDLE ignored");
        cyc(1, 16'h0200, 0, 0, "R5 arm");
        cyc(1, 16'h0204, 0, 0, "R5 fire");
        expect_trig(1'b1, "R5");
        cyc(1, 16'h0204, 0, 0, "R5 DONE ignores B");
        expect_trig(1'b0, "R5");

        // R6: event-only, R7: detail override
        set_ctrl(4'd5, 0, 0, 1, 4'b0000, "R3");
        cyc(1, 16'h0200, 0, 0, "R6 arm");
        cyc(1, 16'h0204, 0, 0, "R6 first event");
        cyc(1, 16'h0204, 0, 0, "R6 repeat event");
        expect_trig(1'b1, "R6");
        set_ctrl(4'd5, 0, 1, 1, 4'b0000, "R3");
        cyc(1, 16'h0200, 0, 0, "R7 arm");
        cyc(1, 16'h0204, 0, 0, "R7 single fire end type");
        cyc(1, 16'h0204, 0, 0, "R7 no repeat");
        expect_trig(1'b0, "R7");
        set_ctrl(4'd4, 0, 1, 1, 4'b0000, "R3");
        cyc(1, 16'h0204, 0, 0, "R7 event-only B as B only");

        // R8: full modes, R13 direction
        set_ctrl(4'd6, 0, 0, 0, 4'b1100, "R3");
        cyc(1, 16'h0200, 0, 0, "R8 A and B dir fails");
        cyc(1, 16'h0200, 1, 0, "R8 A and B dir holds");
        set_ctrl(4'd7, 0, 0, 0, 4'b1100, "R3");
        cyc(1, 16'h0200, 1, 0, "R8 A and not B no fire");
        cyc(1, 16'h0200, 0, 0, "R8 A and not B fires");
        set_ctrl(4'd7, 1, 0, 0, 4'b1100, "R3");
        cyc(1, 16'h0201, 1, 0, "R8 R11 word select reduces to A only");
        expect_trig(1'b1, "R8");
        set_ctrl(4'd1, 0, 0, 0, 4'b0011, "R3");
        cyc(1, 16'h0200, 0, 0, "R13 A direction mismatch");
        expect_trig(1'b0, "R13");
        cyc(1, 16'h0200, 1, 0, "R13 A direction match");

        // R9, R12: inside, straddling word
        wr(2'd1, 16'h0301, "R3");
        wr(2'd2, 16'h0310, "R3");
        set_ctrl(4'd8, 0, 0, 0, 4'b0000, "R3");
        cyc(1, 16'h0300, 0, 0, "R12 inside straddle at lower bound");
        expect_trig(1'b0, "R12");
        cyc(1, 16'h0310, 0, 0, "R9 inside upper bound");
        expect_trig(1'b1, "R9");
        cyc(0, 16'h0000, 0, 1, "R3 clear");
        cyc(1, 16'h0311, 0, 0, "R9 only A bound holds");
        expect_trig(1'b0, "R9");
        set_ctrl(4'd8, 1, 0, 0, 4'b0000, "R3");
        cyc(1, 16'h0300, 0, 0, "R11 word select inside");
        expect_trig(1'b1, "R11");

        // R10: outside
        set_ctrl(4'd9, 0, 0, 0, 4'b0000, "R3");
        cyc(1, 16'h0300, 0, 0, "R10 R12 below A");
        expect_trig(1'b1, "R10");
        cyc(1, 16'h0305, 0, 0, "R10 inside no fire");
        cyc(1, 16'h0311, 0, 0, "R10 above B");

        // R14: reserved code
        set_ctrl(4'd12, 0, 0, 1, 4'b0000, "R3");
        cyc(1, 16'h0301, 0, 0, "R14 reserved");
        cyc(1, 16'h0310, 0, 0, "R14 reserved");

        // random mix against the expected-state functions (R2..R14)
        for (int k = 0; k < 30; k++) begin
            logic [AW-1:0] base;
            base = 16'h1000;
            wr(2'd1, base + 16'($urandom % 12), "R3");
            wr(2'd2, base + 16'($urandom % 16), "R3");
            set_ctrl(4'($urandom % 16), 1'($urandom), 1'($urandom), 1'($urandom),
                     4'($urandom), "R3");
            for (int j = 0; j < 40; j++) begin
                cyc(($urandom % 4) != 0, base + 16'($urandom % 20), 1'($urandom),
                    ($urandom % 25) == 0, "R2 random");
            end
        end

        finish_run();
    end
endmodule